// File: doc/BRIEF.md
# Two-Stage Stereo Audio Decimator

This block takes a stereo delta-sigma stream, one short signed word per channel per input strobe at 128 times the audio sample rate, and turns it into 20-bit words at the audio sample rate. Both channels are filtered side by side with identical arithmetic. Their results leave on one output bus, left first and right second.

Rate reduction happens in two steps. A third-order comb-integrator (sinc cubed) section reduces the rate by 16. A chain of three identical 11-tap half-band FIR sections follows, each reducing the rate by 2. The half-band sections run at fractional precision, and the result is rounded and clamped to 20 bits only once, at the output. A strobe passes from one section to the next only on the samples that section keeps. Successive input strobes may be back to back or separated by idle cycles.

Top module: `audio_decim`

## Requirements
- R1: While `rst_n` is low, and after it is released until the 128th accepted input strobe, `out_valid` stays low.
- R2: For each channel, the sinc section forms three cascaded running sums of the input. On every 16th accepted strobe (the 16th, 32nd, and so on), it outputs the third difference of the last sum taken at the kept strobes. This gives a DC gain of 4096.
- R3: Each half-band section uses the tap weights 3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3 over 512, applied to the newest 11 samples it has received. It emits a result on its 2nd, 4th, 6th and later received samples. Each result equals floor((sum + 256) / 512).
- R4: Exactly one left/right output pair is produced for every 128 accepted input strobes.
- R5: The left result appears with `out_chan` = 0. The right result of the same sample follows on the next cycle with `out_chan` = 1.
- R6: The sinc result is scaled by 256 before the half-band chain. The output word is floor((y + 8) / 16) of the last half-band result y, clamped to the range -524288 to 524287.
- R7: Data on `in_left` and `in_right` has no effect in cycles where `in_valid` is low.
- R8: A constant input x on a channel settles to an output of exactly 65536 times x. For example, 7 gives 458752 and -8 gives -524288.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the input words this cycle |
| in_left | input | IN_W (4) | Left oversampled word, signed |
| in_right | input | IN_W (4) | Right oversampled word, signed |
| out_valid | output | 1 | Output word valid |
| out_chan | output | 1 | 0 = left, 1 = right |
| out_data | output | OUT_W (20) | Decimated sample, signed |

## Verification
The assertions check the following on every cycle:
- left results are always followed at once by right results;
- the sinc section only fires in the cycle after an accepted strobe;
- each half-band section only fires after its upstream section fired;
- no output appears before 128 strobes have been accepted.

The numerical behaviour can only be shown by the bench's scenarios, which compare every output word against an independent integer model. This covers the tap weights, the floor rounding, the DC gain, the clamping after full-scale steps, and the fact that data is ignored between strobes.

// File: rtl/audio_decim.sv
module audio_decim #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 20,
  parameter int HB_W  = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_left,
  input  logic signed [IN_W-1:0]  in_right,
  output logic                    out_valid,
  output logic                    out_chan,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int CIC_R  = 16;
  localparam int CIC_N  = 3;
  localparam int PH_W   = $clog2(CIC_R);
  localparam int CIC_W  = IN_W + CIC_N * PH_W;
  localparam int FRAC   = 8;
  localparam int OUT_SH = FRAC - (OUT_W - CIC_W);
  localparam int HB_N   = 3;
  localparam int TAPS   = 11;
  localparam int HB_SH  = 9;
  localparam int CSH    = HB_SH - 1;
  localparam int ACC_W  = HB_W + 11;
  localparam logic signed [ACC_W-1:0] C0 = 3;
  localparam logic signed [ACC_W-1:0] C2 = -25;
  localparam logic signed [ACC_W-1:0] C4 = 150;
  localparam logic signed [ACC_W-1:0] HB_RND = 1 <<< (HB_SH - 1);
  localparam logic signed [HB_W:0] O_RND = 1 <<< (OUT_SH - 1);
  localparam logic signed [HB_W:0] O_MAX = (2 ** (OUT_W - 1)) - 1;
  localparam logic signed [HB_W:0] O_MIN = -(2 ** (OUT_W - 1));

  logic signed [CIC_W-1:0] i1[2], i2[2], i3[2], z1[2], z2[2], z3[2];
  logic signed [CIC_W-1:0] n1[2], n2[2], n3[2], d1[2], d2[2], d3[2], cq[2];
  logic [PH_W-1:0] phase;
  logic keep, cic_v;

  assign keep = in_valid && (phase == PH_W'(CIC_R - 1));

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      logic signed [IN_W-1:0] xi;
      xi    = (c == 0) ? in_left : in_right;
      n1[c] = i1[c] + CIC_W'(xi);
      n2[c] = i2[c] + n1[c];
      n3[c] = i3[c] + n2[c];
      d1[c] = n3[c] - z1[c];
      d2[c] = d1[c] - z2[c];
      d3[c] = d2[c] - z3[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      cic_v <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        i1[c] <= '0; i2[c] <= '0; i3[c] <= '0;
        z1[c] <= '0; z2[c] <= '0; z3[c] <= '0;
        cq[c] <= '0;
      end
    end else begin
      cic_v <= keep;
      if (in_valid) begin
        phase <= phase + 1'b1;
        for (int c = 0; c < 2; c++) begin
          i1[c] <= n1[c];
          i2[c] <= n2[c];
          i3[c] <= n3[c];
          if (keep) begin
            z1[c] <= n3[c];
            z2[c] <= d1[c];
            z3[c] <= d2[c];
            cq[c] <= d3[c];
          end
        end
      end
    end
  end

  logic signed [HB_W-1:0] sd[HB_N+1][2];
  logic [HB_N:0] sv;

  assign sd[0][0] = HB_W'(cq[0]) <<< FRAC;
  assign sd[0][1] = HB_W'(cq[1]) <<< FRAC;
  assign sv[0]    = cic_v;

  for (genvar s = 0; s < HB_N; s++) begin : g_hb
    logic signed [HB_W-1:0]  dl[2][TAPS-1];
    logic signed [HB_W-1:0]  q[2];
    logic signed [ACC_W-1:0] acc[2];
    logic odd, v;

    always_comb begin
      for (int c = 0; c < 2; c++) begin
        acc[c] = C0 * (ACC_W'(sd[s][c]) + ACC_W'(dl[c][9]))
               + C2 * (ACC_W'(dl[c][1]) + ACC_W'(dl[c][7]))
               + C4 * (ACC_W'(dl[c][3]) + ACC_W'(dl[c][5]))
               + (ACC_W'(dl[c][4]) <<< CSH)
               + HB_RND;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        odd <= 1'b0;
        v   <= 1'b0;
        for (int c = 0; c < 2; c++) begin
          q[c] <= '0;
          for (int k = 0; k < TAPS - 1; k++) dl[c][k] <= '0;
        end
      end else begin
        v <= sv[s] && odd;
        if (sv[s]) begin
          odd <= ~odd;
          for (int c = 0; c < 2; c++) begin
            dl[c][0] <= sd[s][c];
            for (int k = 1; k < TAPS - 1; k++) dl[c][k] <= dl[c][k-1];
            if (odd) q[c] <= HB_W'(acc[c] >>> HB_SH);
          end
        end
      end
    end

    assign sd[s+1] = q;
    assign sv[s+1] = v;
  end

  function automatic logic signed [OUT_W-1:0] clamp_out(input logic signed [HB_W-1:0] y);
    logic signed [HB_W:0] r;
    r = ((HB_W+1)'(y) + O_RND) >>> OUT_SH;
    if (r > O_MAX)      r = O_MAX;
    else if (r < O_MIN) r = O_MIN;
    return OUT_W'(r);
  endfunction

  logic signed [OUT_W-1:0] r_hold;
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
      r_hold    <= '0;
      pend      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (sv[HB_N]) begin
        out_valid <= 1'b1;
        out_chan  <= 1'b0;
        out_data  <= clamp_out(sd[HB_N][0]);
        r_hold    <= clamp_out(sd[HB_N][1]);
        pend      <= 1'b1;
      end else if (pend) begin
        out_valid <= 1'b1;
        out_chan  <= 1'b1;
        out_data  <= r_hold;
        pend      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_decim_chk.sv
module audio_decim_chk #(
  parameter int N = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       out_chan,
  input logic [N:0] sv
);
  logic [7:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != 8'd128) seen <= seen + 8'd1;
  end

  assert_no_early_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen == 8'd128);

  assert_sinc_from_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sv[0] |-> $past(in_valid));

  for (genvar s = 0; s < N; s++) begin : g_a
    assert_hb_from_upstream_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sv[s+1] |-> $past(sv[s]));
  end

  assert_left_from_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_chan) |-> $past(sv[N]));

  assert_right_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_chan) |=> (out_valid && out_chan));

  assert_right_after_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_chan) |-> $past(out_valid && !out_chan));
endmodule

bind audio_decim audio_decim_chk #(.N(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_chan(out_chan), .sv(sv)
);

// File: tb/audio_decim_tb_top.sv
`timescale 1ns/1ps
module audio_decim_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [3:0] in_left = '0, in_right = '0;
  logic out_valid, out_chan;
  logic signed [19:0] out_data;

  always #5 clk = ~clk;

  audio_decim dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );

  int total = 0, bad = 0;
  int strobes = 0, outs = 0;
  longint last_v[2];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model
  longint mi1[2], mi2[2], mi3[2], mz1[2], mz2[2], mz3[2];
  longint mh[3][2][11];
  bit modd[3];
  int mph = 0;
  longint exp_q[$];
  bit ch_q[$];
  int hc[11] = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};

  function automatic longint clamp20(input longint y);
    longint r;
    r = (y + 8) >>> 4;
    if (r > 524287) r = 524287;
    if (r < -524288) r = -524288;
    return r;
  endfunction

  task automatic model_step(input longint xl, input longint xr);
    longint v[2];
    bit go;
    go = 0;
    for (int c = 0; c < 2; c++) begin
      mi1[c] += (c == 0) ? xl : xr;
      mi2[c] += mi1[c];
      mi3[c] += mi2[c];
    end
    if (mph == 15) begin
      for (int c = 0; c < 2; c++) begin
        longint a, b, d;
        a = mi3[c] - mz1[c]; mz1[c] = mi3[c];
        b = a - mz2[c];      mz2[c] = a;
        d = b - mz3[c];      mz3[c] = b;
        v[c] = d * 256;
      end
      go = 1;
    end
    mph = (mph + 1) % 16;
    for (int s = 0; s < 3; s++) begin
      if (go) begin
        for (int c = 0; c < 2; c++) begin
          for (int k = 10; k > 0; k--) mh[s][c][k] = mh[s][c][k-1];
          mh[s][c][0] = v[c];
        end
        if (modd[s]) begin
          for (int c = 0; c < 2; c++) begin
            longint acc;
            acc = 256;
            for (int k = 0; k < 11; k++) acc += hc[k] * mh[s][c][k];
            v[c] = acc >>> 9;
          end
        end
        modd[s] = !modd[s];
        if (!modd[s]) ; else go = 0;
      end
    end
    if (go) begin
      exp_q.push_back(clamp20(v[0])); ch_q.push_back(1'b0);
      exp_q.push_back(clamp20(v[1])); ch_q.push_back(1'b1);
    end
  endtask

  task automatic send(input int l, input int r, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 4'(l);
    in_right = 4'(r);
    strobes++;
    model_step(l, r);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_left  = 4'($urandom);
      in_right = 4'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard (R3 R5 R6 R7 compared on every word)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      outs++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected output", out_data, 0);
      end else begin
        longint e;
        bit ec;
        e  = exp_q.pop_front();
        ec = ch_q.pop_front();
        chk(out_chan == ec, "R5 channel tag", out_chan, ec);
        chk(longint'(out_data) == e, "R3 R6 R7 data vs model", out_data, e);
        last_v[out_chan] = out_data;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;

    // R1: 127 strobes produce nothing
    for (int i = 0; i < 127; i++) send(7, -3, 0);
    idle(10);
    chk(outs == 0, "R1 no output before 128 strobes", outs, 0);

    // R8 / R2: DC settles to 65536*x
    for (int i = 0; i < 128 * 24 - 127; i++) send(7, -3, 0);
    idle(12);
    chk(last_v[0] == 458752, "R8 R2 DC left", last_v[0], 458752);
    chk(last_v[1] == -196608, "R8 R2 DC right", last_v[1], -196608);

    // R8 / R6: negative full scale with gaps
    for (int i = 0; i < 128 * 24; i++) send(-8, -8, 1);
    idle(12);
    chk(last_v[0] == -524288, "R8 R6 DC min left", last_v[0], -524288);
    chk(last_v[1] == -524288, "R8 R6 DC min right", last_v[1], -524288);

    // R7 R3: random data, random gaps with junk between strobes
    for (int i = 0; i < 128 * 20; i++)
      send(int'($urandom_range(0, 15)) - 8, int'($urandom_range(0, 15)) - 8, int'($urandom_range(0, 3)));

    // R6: full-scale steps drive overshoot into the clamp
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 512; i++)
        send(b[0] ? -8 : 7, b[0] ? 7 : -8, 0);

    idle(20);
    chk(exp_q.size() == 0, "R4 all expected words seen", exp_q.size(), 0);
    chk(outs == 2 * (strobes / 128), "R4 pair count", outs, 2 * (strobes / 128));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule